// File: doc/BRIEF.md
# Compatibility-Mode Register Move Unit

This block carries 24-bit values between an external data bus and a local bank of eleven control registers. Nine of them are program-control registers: loop address, loop counter, stack pointer, stack size limit, stack high, extension pointer, stack size, vector base and stack counter. The other two are the status register and the operating-mode register. Each accepted move names one source and one destination. The source is a register or the external write data. The destination is a register, or the bus alone, in which case no register is written.

A single compatibility bit puts the unit in a legacy 16-bit mode. In that mode the top byte of a transfer is either zeroed or left alone. Which one applies depends on whether the register is read or written, and on whether it is a program-control register or one of the two status-class registers.

Changes to the compatibility bit pass through a fixed three-stage delay before the masking logic sees them. This matches an instruction pipeline in which the new mode applies only three instructions after the one that wrote it. Every moved value is returned on a registered read port. All register contents are also exposed as a flat vector for the neighbouring logic.

Top module: `rvm_move_unit`

## Requirements
- R1: When the effective compatibility mode is 1, a move whose destination is a program-control register (select codes 0 to 8) writes bits 23:16 as zero and bits 15:0 from the source value.
- R2: When the effective compatibility mode is 1 and the source is any register (codes 0 to 10), the transferred value has bits 23:16 cleared. This is the value returned on rd_data, and it is the value passed to the destination rule.
- R3: When the effective compatibility mode is 1 and the destination is the status register (code 9) or the operating-mode register (code 10), bits 23:16 of that register keep their old value and bits 15:0 are written. This rule applies after R2, so a status-to-status-class move keeps the destination's top byte.
- R4: When the effective mode is 0, every move transfers all 24 bits unchanged. This is the only way to alter bits 23:16 of the status and operating-mode registers.
- R5: Take a mode write (mode_we=1, value mode_wd) sampled at clock edge k. Moves sampled at edges k, k+1 and k+2 use the previous mode, and moves from edge k+3 onward use mode_wd. mode_eff shows the new value from the cycle after edge k+2.
- R6: Select codes are as follows: 0 to 8 are the program-control registers in the order listed, 9 is status, 10 is operating-mode, and 11 to 15 mean the external bus. As a source, the bus supplies mv_wdata. As a destination, the bus means no register is written.
- R7: One cycle after an accepted move, rd_valid is 1 and rd_data holds the transferred value after R2. After a cycle with mv_valid=0, rd_valid is 0 and rd_data keeps its value.
- R8: Registers change only on an accepted move that names them as destination. mv_wdata changes and mode writes leave them unchanged.
- R9: Synchronous reset clears all registers, rd_data, rd_valid and the compatibility mode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mv_valid | input | 1 | A move is requested this cycle |
| mv_src | input | 4 | Source select code |
| mv_dst | input | 4 | Destination select code |
| mv_wdata | input | 24 | External bus data used when the source is the bus |
| mode_we | input | 1 | Write strobe for the compatibility bit |
| mode_wd | input | 1 | New compatibility bit value |
| rd_data | output | 24 | Transferred value of the last accepted move |
| rd_valid | output | 1 | rd_data was updated by the previous cycle's move |
| reg_flat | output | 264 | All eleven registers, register n at bits n*24+23 : n*24 |
| mode_eff | output | 1 | Compatibility mode currently applied to moves |

## Verification
The hardest case to reach is a move that lands inside the three-cycle window after a mode write, especially when a second mode write is already in flight behind the first. The stimulus writes the mode bit and then issues a move on every one of the following cycles, so the moment the new rule takes over is visible in the register contents. It also sends a 1-then-0 pulse on two consecutive cycles, which opens a one-cycle window of compatibility mode three cycles later. A long pseudo-random phase mixes mode writes into dense move traffic, and a cycle-level model checks every cycle.

// File: rtl/rvm_pkg.sv
package rvm_pkg;

  // Register class derived from a select code
  typedef enum logic [1:0] {
    CLS_CTRL = 2'd0,  // program-control register
    CLS_STAT = 2'd1,  // status or operating-mode register
    CLS_BUS  = 2'd2   // external bus, no register
  } sel_cls_e;

  function automatic sel_cls_e classify(input int unsigned sel, input int unsigned n_ctrl);
    if (sel < n_ctrl)            return CLS_CTRL;
    else if (sel < n_ctrl + 2)   return CLS_STAT;
    else                         return CLS_BUS;
  endfunction

endpackage

// File: rtl/rvm_mode_pipe.sv
module rvm_mode_pipe #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic wd,
  output logic eff
);
  logic [DEPTH-1:0] stg;

  // stg[0] is the written bit; the last stage is what the masking logic sees
  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= we ? wd : stg[0];
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign eff = stg[DEPTH-1];
endmodule

// File: rtl/rvm_mask.sv
module rvm_mask
  import rvm_pkg::*;
#(
  parameter int DW = 24,
  parameter int UB = 8
) (
  input  logic          compat,
  input  sel_cls_e      src_cls,
  input  sel_cls_e      dst_cls,
  input  logic [DW-1:0] src_val,
  input  logic [DW-1:0] dst_old,
  output logic [DW-1:0] xfer_val,
  output logic [DW-1:0] wr_val
);
  always_comb begin
    // source rule: register reads lose their top byte
    xfer_val = src_val;
    if (compat && src_cls != CLS_BUS) xfer_val[DW-1 -: UB] = '0;
    // destination rule, applied after the source rule
    wr_val = xfer_val;
    if (compat) begin
      unique case (dst_cls)
        CLS_CTRL: wr_val[DW-1 -: UB] = '0;
        CLS_STAT: wr_val[DW-1 -: UB] = dst_old[DW-1 -: UB];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/rvm_regbank.sv
module rvm_regbank #(
  parameter int DW   = 24,
  parameter int NREG = 11,
  parameter int AW   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                            q <= '0;
      else if (we && waddr == AW'(g))     q <= wdata;
    end
    assign flat[g*DW +: DW] = q;
  end
endmodule

// File: rtl/rvm_move_unit.sv
module rvm_move_unit
  import rvm_pkg::*;
#(
  parameter int DW       = 24,
  parameter int UB       = 8,
  parameter int NCTRL    = 9,
  parameter int MODE_DLY = 3,
  localparam int NREG    = NCTRL + 2,
  localparam int SELW    = $clog2(NCTRL + 3)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mv_valid,
  input  logic [SELW-1:0]    mv_src,
  input  logic [SELW-1:0]    mv_dst,
  input  logic [DW-1:0]      mv_wdata,
  input  logic               mode_we,
  input  logic               mode_wd,
  output logic [DW-1:0]      rd_data,
  output logic               rd_valid,
  output logic [NREG*DW-1:0] reg_flat,
  output logic               mode_eff
);
  sel_cls_e      src_cls, dst_cls;
  logic [DW-1:0] src_val, dst_old, xfer_val, wr_val;

  assign src_cls = classify(32'(mv_src), NCTRL);
  assign dst_cls = classify(32'(mv_dst), NCTRL);

  // read muxes for source value and destination's current value
  always_comb begin
    src_val = mv_wdata;
    dst_old = '0;
    for (int i = 0; i < NREG; i++) begin
      if (mv_src == SELW'(i)) src_val = reg_flat[i*DW +: DW];
      if (mv_dst == SELW'(i)) dst_old = reg_flat[i*DW +: DW];
    end
  end

  rvm_mode_pipe #(.DEPTH(MODE_DLY)) u_mode (
    .clk (clk),
    .rst (rst),
    .we  (mode_we),
    .wd  (mode_wd),
    .eff (mode_eff)
  );

  rvm_mask #(.DW(DW), .UB(UB)) u_mask (
    .compat   (mode_eff),
    .src_cls  (src_cls),
    .dst_cls  (dst_cls),
    .src_val  (src_val),
    .dst_old  (dst_old),
    .xfer_val (xfer_val),
    .wr_val   (wr_val)
  );

  rvm_regbank #(.DW(DW), .NREG(NREG), .AW(SELW)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (mv_valid && dst_cls != CLS_BUS),
    .waddr (mv_dst),
    .wdata (wr_val),
    .flat  (reg_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= mv_valid;
      if (mv_valid) rd_data <= xfer_val;
    end
  end
endmodule

// File: rtl/rvm_move_unit_chk.sv
module rvm_move_unit_chk #(
  parameter int DW       = 24,
  parameter int UB       = 8,
  parameter int NCTRL    = 9,
  parameter int MODE_DLY = 3,
  localparam int NREG    = NCTRL + 2,
  localparam int SELW    = $clog2(NCTRL + 3)
) (
  input logic               clk,
  input logic               rst,
  input logic               mv_valid,
  input logic [SELW-1:0]    mv_src,
  input logic [SELW-1:0]    mv_dst,
  input logic [DW-1:0]      mv_wdata,
  input logic               mode_we,
  input logic               mode_wd,
  input logic [DW-1:0]      rd_data,
  input logic               rd_valid,
  input logic [NREG*DW-1:0] reg_flat,
  input logic               mode_eff
);
  logic [SELW-1:0] dst_q;
  logic [DW-1:0]   dst_now, dst_after;

  always_ff @(posedge clk) begin
    if (rst) dst_q <= '0;
    else     dst_q <= mv_dst;
  end

  always_comb begin
    dst_now   = '0;
    dst_after = '0;
    for (int i = 0; i < NREG; i++) begin
      if (mv_dst == SELW'(i)) dst_now   = reg_flat[i*DW +: DW];
      if (dst_q  == SELW'(i)) dst_after = reg_flat[i*DW +: DW];
    end
  end

  a_r1_ctrl_top_cleared: assert property (@(posedge clk) disable iff (rst)
    (mv_valid && mode_eff && int'(mv_dst) < NCTRL) |=> (dst_after[DW-1 -: UB] == '0));

  a_r2_src_top_cleared: assert property (@(posedge clk) disable iff (rst)
    (mv_valid && mode_eff && int'(mv_src) < NREG) |=> (rd_data[DW-1 -: UB] == '0));

  a_r3_stat_top_kept: assert property (@(posedge clk) disable iff (rst)
    (mv_valid && mode_eff && int'(mv_dst) >= NCTRL && int'(mv_dst) < NREG)
      |=> (dst_after[DW-1 -: UB] == $past(dst_now[DW-1 -: UB])));

  a_r4_full_width: assert property (@(posedge clk) disable iff (rst)
    (mv_valid && !mode_eff && int'(mv_dst) < NREG && int'(mv_src) >= NREG)
      |=> (dst_after == $past(mv_wdata)));

  if (MODE_DLY == 3) begin : g_dly
    a_r5_mode_delay: assert property (@(posedge clk) disable iff (rst)
      mode_we |=> ##2 (mode_eff == $past(mode_wd, 3)));
  end

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    mv_valid |=> rd_valid);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !mv_valid |=> (!rd_valid && $stable(rd_data)));

  a_r8_regs_hold: assert property (@(posedge clk) disable iff (rst)
    (!mv_valid || int'(mv_dst) >= NREG) |=> $stable(reg_flat));

  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (reg_flat == '0 && !rd_valid && rd_data == '0 && !mode_eff));
endmodule

bind rvm_move_unit rvm_move_unit_chk #(
  .DW(DW), .UB(UB), .NCTRL(NCTRL), .MODE_DLY(MODE_DLY)
) u_chk (.*);

// File: tb/rvm_move_unit_tb.sv
module rvm_move_unit_tb_top;
  localparam int DW   = 24;
  localparam int NREG = 11;
  localparam int NCT  = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mv_valid = 1'b0;
  logic [3:0] mv_src = '0, mv_dst = '0;
  logic [DW-1:0] mv_wdata = '0;
  logic mode_we = 1'b0, mode_wd = 1'b0;
  logic [DW-1:0] rd_data;
  logic rd_valid;
  logic [NREG*DW-1:0] reg_flat;
  logic mode_eff;

  always #2 clk = ~clk;  // 250 MHz

  rvm_move_unit dut_i (.*);

  // reference state
  logic [DW-1:0] m_reg [NREG];
  logic [DW-1:0] m_rd;
  logic m_rv;
  logic m_st [3];
  int   errors = 0, checks = 0;
  bit   done = 0;
  string tag = "R9";

  task automatic model_update();
    logic cm;
    logic [DW-1:0] s;
    if (rst) begin
      for (int i = 0; i < NREG; i++) m_reg[i] = '0;
      m_rd = '0; m_rv = 0;
      for (int i = 0; i < 3; i++) m_st[i] = 0;
      return;
    end
    cm = m_st[2];
    if (mv_valid) begin
      s = (int'(mv_src) < NREG) ? m_reg[mv_src] : mv_wdata;
      if (cm && int'(mv_src) < NREG) s[23:16] = 8'h00;
      m_rd = s;
      if (int'(mv_dst) < NCT)       m_reg[mv_dst] = cm ? {8'h00, s[15:0]} : s;
      else if (int'(mv_dst) < NREG) m_reg[mv_dst] = cm ? {m_reg[mv_dst][23:16], s[15:0]} : s;
    end
    m_rv = mv_valid;
    m_st[2] = m_st[1];
    m_st[1] = m_st[0];
    if (mode_we) m_st[0] = mode_wd;
  endtask

  task automatic compare();
    checks++;
    if (rd_valid !== m_rv) begin
      errors++; $display("FAIL %s rd_valid act=%b exp=%b", tag, rd_valid, m_rv);
    end
    checks++;
    if (rd_data !== m_rd) begin
      errors++; $display("FAIL %s rd_data act=%h exp=%h", tag, rd_data, m_rd);
    end
    checks++;
    if (mode_eff !== m_st[2]) begin
      errors++; $display("FAIL %s mode_eff act=%b exp=%b", tag, mode_eff, m_st[2]);
    end
    checks++;
    for (int i = 0; i < NREG; i++) begin
      if (reg_flat[i*DW +: DW] !== m_reg[i]) begin
        errors++;
        $display("FAIL %s reg%0d act=%h exp=%h", tag, i, reg_flat[i*DW +: DW], m_reg[i]);
        break;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic mv(input int s, input int d, input logic [DW-1:0] w);
    mv_valid = 1; mv_src = 4'(s); mv_dst = 4'(d); mv_wdata = w;
    tick();
    mv_valid = 0;
  endtask

  task automatic setmode(input logic v);
    mode_we = 1; mode_wd = v;
    tick();
    mode_we = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int unsigned r;
    tag = "R9";
    repeat (3) tick();
    rst = 0;
    tick();  // R9 reset state observed

    // R4 / R6: mode off, full-width loads to every register, then copies
    tag = "R4/R6";
    for (int i = 0; i < NREG; i++) mv(11 + (i % 5), i, 24'hA50000 ^ (24'(i) * 24'h131313));
    mv(9, 3, 24'h0);
    mv(2, 10, 24'h0);
    mv(5, 14, 24'h0);
    tag = "R7";
    mv_wdata = 24'h123456;
    tick(); tick();

    // R5: mode on, moves on each cycle across the window
    tag = "R5";
    mode_we = 1; mode_wd = 1;
    mv(11, 0, 24'hFFFFFF);
    mode_we = 0;
    for (int i = 0; i < 5; i++) mv(12, 0, 24'hFEDCBA ^ 24'(i));

    // R1: control destinations under compat
    tag = "R1";
    for (int i = 0; i < NCT; i++) mv(13, i, 24'hC3A000 | 24'(i));
    // R2: register sources to bus and registers
    tag = "R2";
    mv(9, 11, 24'h0);
    mv(10, 4, 24'h0);
    mv(6, 15, 24'h0);
    // R3: status-class destinations keep top byte
    tag = "R3";
    mv(11, 9, 24'hEE1234);
    mv(12, 10, 24'h77ABCD);
    mv(10, 9, 24'h0);
    mv(3, 10, 24'h0);

    // R4: back to off, status top byte changeable again
    tag = "R4";
    setmode(0);
    mv(11, 9, 24'h5A5A5A);
    mv(11, 9, 24'h99FFFF);
    mv(11, 10, 24'hF00F0F);
    mv(9, 11, 24'h0);

    // R5: 1-then-0 pulse; one-cycle compat window three cycles later
    tag = "R5";
    mode_we = 1; mode_wd = 1; tick();
    mode_wd = 0; tick();
    mode_we = 0;
    for (int i = 0; i < 5; i++) mv(11, 9, 24'hAB0000 | 24'(i * 17));

    // R8: idle with changing data and mode writes
    tag = "R8";
    for (int i = 0; i < 6; i++) begin
      mv_wdata = 24'(i) * 24'h1F1F1F; mv_src = 4'(i); mv_dst = 4'(i);
      mode_we = i[0]; mode_wd = i[1];
      tick();
    end
    mode_we = 0;

    // mixed pseudo-random traffic
    tag = "R1/R2/R3/R4/R5/R7";
    r = 32'h1234_5678;
    for (int n = 0; n < 500; n++) begin
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      mv_valid = r[0] | r[1];
      mv_src   = r[5:2];
      mv_dst   = r[9:6];
      mv_wdata = r[31:8];
      mode_we  = (r[20:17] == 4'd0);
      mode_wd  = r[21];
      tick();
    end
    mv_valid = 0; mode_we = 0;

    // R9: reset in the middle of activity
    tag = "R9";
    rst = 1; tick();
    rst = 0; tick();
    summary();
  end
endmodule